// File: doc/BRIEF.md
# Microsequencer Next-PC Selection Unit

This block owns the program counter of a microsequencer that runs a 64-bit horizontal instruction word. Every cycle it receives the decoded fields of the current instruction: category, next-PC source select, jump condition and call-hardware operation. It also receives the address bits of the word, the ALU output register, the return PC offered by the call hardware, the ALU carry and zero flags and a jump-indirect control bit. From these it loads the PC for the following instruction.

The jump condition written into an instruction governs the branch of the instruction after it. The unit therefore holds that code in a pipeline register and tests it against the flags present when the next instruction executes. When the test fails, execution falls through to PC+1. When the instruction word itself supplies the target, the category decides how much of the address field is used and where it lands. An address-category word gives a full-width target. A plain or alternate ALU word gives either a branch inside the current 4K page or, when the call hardware is calling, a subroutine entry inside cluster zero. A combinational flag marks field combinations that have no defined target.

Top module: `useq_next_pc`

## Requirements
- R1: A synchronous active-high `rst` sets `pc` to 0 and loads the held jump condition with code 1 (always), so the first instruction after reset is never gated off.
- R2: `npc_sel` picks the target source: 0 = address from the instruction word, 1 = `alu_out`, 2 = `ret_pc`, 3 = `pc`+1.
- R3: With `npc_sel`=0 and `cat`=3 (address category), the target is the full `addr_field[22:0]`.
- R4: With `npc_sel`=0, `cat` of 0 or 4 (ALU or alternate ALU), and `call_op` not 4, 5 or 6, the target keeps `pc[22:12]` and takes bits 11..0 from `addr_field[11:0]`.
- R5: With `npc_sel`=0, `cat` of 0 or 4, and `call_op` of 4 (call), 5 (open-and-call) or 6 (tail call), the target is `addr_field[11:4]` placed at bits 11..4, with every other bit zero.
- R6: `npc_sel`=2 while `call_op` is not 7 (return) raises `illegal` in the same cycle, and the next PC is `pc`+1.
- R7: `npc_sel`=0 with `cat` of 1, 2, 5, 6 or 7 (no jump address in the word) raises `illegal` in the same cycle, and the next PC is `pc`+1.
- R8: Jump-condition codes are: 0 = `jindir`, 1 = always, 2 = carry, 3 = not carry, 4 = zero, 5 = not zero, 6 = carry or zero, 7 = neither carry nor zero.
- R9: The `jcond` of an instruction gates the next non-stalled instruction. It is tested against the `flag_c`, `flag_z` and `jindir` values present during that later instruction.
- R10: When the held condition is false, the next PC is `pc`+1 whatever `npc_sel` is.
- R11: While `stall` is high, `pc` and the held jump condition keep their values.
- R12: `pc`+1 wraps from 23'h7FFFFF to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Hold PC and held condition |
| cat | input | 3 | Instruction category |
| npc_sel | input | 2 | Next-PC source select |
| jcond | input | 3 | Jump condition for the following instruction |
| call_op | input | 3 | Call-hardware operation code |
| addr_field | input | 23 | Address bits of the instruction word |
| alu_out | input | 23 | ALU output register |
| ret_pc | input | 23 | Return PC from the call hardware |
| flag_c | input | 1 | ALU carry flag |
| flag_z | input | 1 | ALU zero flag |
| jindir | input | 1 | Jump-indirect control bit |
| pc | output | 23 | Current program counter |
| illegal | output | 1 | Undefined field combination in this instruction |

## Verification
A fault in the held jump condition does not show on the cycle that writes it. It shows one instruction later, as a wrong choice between the target and PC+1. The bench therefore pairs every condition code with a following jump and drives opposite flag values on the two instructions. A fault in target formation shows in `pc` on the edge right after the instruction, most plainly in the kept page bits and the zeroed call-form bits. A decode fault in `illegal` shows at the port in the same cycle, and as a missing fall-through on the next edge.

// File: rtl/useq_pkg.sv
package useq_pkg;

    typedef enum logic [1:0] {
        NPC_INSTR  = 2'd0,
        NPC_ALUOUT = 2'd1,
        NPC_RETPC  = 2'd2,
        NPC_SEQ    = 2'd3
    } npc_sel_e;

    typedef enum logic [2:0] {
        CAT_ALU   = 3'd0,
        CAT_ALUI  = 3'd1,
        CAT_LOADI = 3'd2,
        CAT_ADDR  = 3'd3,
        CAT_ALUX  = 3'd4,
        CAT_ALUIX = 3'd5,
        CAT_RSV6  = 3'd6,
        CAT_RSV7  = 3'd7
    } cat_e;

    typedef enum logic [2:0] {
        CND_INDIR  = 3'd0,
        CND_ALWAYS = 3'd1,
        CND_CY     = 3'd2,
        CND_NCY    = 3'd3,
        CND_ZR     = 3'd4,
        CND_NZR    = 3'd5,
        CND_CYZ    = 3'd6,
        CND_NCYZ   = 3'd7
    } cond_e;

    typedef enum logic [2:0] {
        COP_NOP      = 3'd0,
        COP_OPEN     = 3'd1,
        COP_TOPEN    = 3'd2,
        COP_SPARE    = 3'd3,
        COP_CALL     = 3'd4,
        COP_OPENCALL = 3'd5,
        COP_TCALL    = 3'd6,
        COP_RETURN   = 3'd7
    } callop_e;

    typedef enum logic [1:0] {
        FORM_FULL  = 2'd0,
        FORM_PAGE  = 2'd1,
        FORM_CALL0 = 2'd2,
        FORM_NONE  = 2'd3
    } form_e;

    typedef struct packed {
        logic cy;
        logic zr;
        logic indir;
    } flags_t;

    function automatic logic cond_holds(cond_e code, flags_t f);
        logic r;
        case (code)
            CND_INDIR:  r = f.indir;
            CND_ALWAYS: r = 1'b1;
            CND_CY:     r = f.cy;
            CND_NCY:    r = ~f.cy;
            CND_ZR:     r = f.zr;
            CND_NZR:    r = ~f.zr;
            CND_CYZ:    r = f.cy | f.zr;
            default:    r = ~(f.cy | f.zr);
        endcase
        return r;
    endfunction

    function automatic logic is_call_op(callop_e op);
        return (op == COP_CALL) || (op == COP_OPENCALL) || (op == COP_TCALL);
    endfunction

    function automatic form_e pick_form(cat_e c, callop_e op);
        form_e f;
        case (c)
            CAT_ADDR:          f = FORM_FULL;
            CAT_ALU, CAT_ALUX: f = is_call_op(op) ? FORM_CALL0 : FORM_PAGE;
            default:           f = FORM_NONE;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/useq_cond_stage.sv
module useq_cond_stage
    import useq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   stall,
    input  cond_e  jcond_i,
    input  flags_t flags_i,
    output logic   take_o
);
    cond_e held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= CND_ALWAYS;
        end else if (!stall) begin
            held_q <= jcond_i;
        end
    end

    always_comb begin
        take_o = cond_holds(held_q, flags_i);
    end
endmodule

// File: rtl/useq_target_gen.sv
module useq_target_gen
    import useq_pkg::*;
#(
    parameter int PC_W    = 23,
    parameter int PAGE_W  = 12,
    parameter int CALL_LO = 4
) (
    input  cat_e            cat_i,
    input  callop_e         cop_i,
    input  logic [PC_W-1:0] addr_i,
    input  logic [PC_W-1:0] pc_i,
    output logic [PC_W-1:0] target_o,
    output logic            no_addr_o
);
    form_e form;

    always_comb begin
        form      = pick_form(cat_i, cop_i);
        no_addr_o = (form == FORM_NONE);
        target_o  = '0;
        case (form)
            FORM_FULL: begin
                target_o = addr_i;
            end
            FORM_PAGE: begin
                target_o[PC_W-1:PAGE_W] = pc_i[PC_W-1:PAGE_W];
                target_o[PAGE_W-1:0]    = addr_i[PAGE_W-1:0];
            end
            FORM_CALL0: begin
                target_o[PAGE_W-1:CALL_LO] = addr_i[PAGE_W-1:CALL_LO];
            end
            default: begin
                target_o = '0;
            end
        endcase
    end
endmodule

// File: rtl/useq_pc_select.sv
module useq_pc_select
    import useq_pkg::*;
#(
    parameter int PC_W = 23
) (
    input  npc_sel_e        sel_i,
    input  callop_e         cop_i,
    input  logic            take_i,
    input  logic            no_addr_i,
    input  logic [PC_W-1:0] target_i,
    input  logic [PC_W-1:0] alu_i,
    input  logic [PC_W-1:0] ret_i,
    input  logic [PC_W-1:0] pc_i,
    output logic [PC_W-1:0] next_o,
    output logic            illegal_o
);
    localparam logic [PC_W-1:0] PC_STEP = PC_W'(1);

    logic [PC_W-1:0] seq_pc;
    logic            bad_ret;
    logic            bad_instr;

    always_comb begin
        seq_pc    = pc_i + PC_STEP;
        bad_ret   = (sel_i == NPC_RETPC) && (cop_i != COP_RETURN);
        bad_instr = (sel_i == NPC_INSTR) && no_addr_i;
        illegal_o = bad_ret | bad_instr;
        if (!take_i || illegal_o) begin
            next_o = seq_pc;
        end else begin
            case (sel_i)
                NPC_INSTR:  next_o = target_i;
                NPC_ALUOUT: next_o = alu_i;
                NPC_RETPC:  next_o = ret_i;
                default:    next_o = seq_pc;
            endcase
        end
    end
endmodule

// File: rtl/useq_next_pc.sv
module useq_next_pc
    import useq_pkg::*;
#(
    parameter int PC_W    = 23,
    parameter int PAGE_W  = 12,
    parameter int CALL_LO = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            stall,
    input  logic [2:0]      cat,
    input  logic [1:0]      npc_sel,
    input  logic [2:0]      jcond,
    input  logic [2:0]      call_op,
    input  logic [PC_W-1:0] addr_field,
    input  logic [PC_W-1:0] alu_out,
    input  logic [PC_W-1:0] ret_pc,
    input  logic            flag_c,
    input  logic            flag_z,
    input  logic            jindir,
    output logic [PC_W-1:0] pc,
    output logic            illegal
);
    flags_t          flags;
    logic            cond_take;
    logic            no_addr;
    logic [PC_W-1:0] target;
    logic [PC_W-1:0] next_pc;
    logic [PC_W-1:0] pc_q;

    always_comb begin
        flags.cy    = flag_c;
        flags.zr    = flag_z;
        flags.indir = jindir;
    end

    useq_cond_stage u_cond (
        .clk     (clk),
        .rst     (rst),
        .stall   (stall),
        .jcond_i (cond_e'(jcond)),
        .flags_i (flags),
        .take_o  (cond_take)
    );

    useq_target_gen #(
        .PC_W    (PC_W),
        .PAGE_W  (PAGE_W),
        .CALL_LO (CALL_LO)
    ) u_tgt (
        .cat_i     (cat_e'(cat)),
        .cop_i     (callop_e'(call_op)),
        .addr_i    (addr_field),
        .pc_i      (pc_q),
        .target_o  (target),
        .no_addr_o (no_addr)
    );

    useq_pc_select #(
        .PC_W (PC_W)
    ) u_sel (
        .sel_i     (npc_sel_e'(npc_sel)),
        .cop_i     (callop_e'(call_op)),
        .take_i    (cond_take),
        .no_addr_i (no_addr),
        .target_i  (target),
        .alu_i     (alu_out),
        .ret_i     (ret_pc),
        .pc_i      (pc_q),
        .next_o    (next_pc),
        .illegal_o (illegal)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else if (!stall) begin
            pc_q <= next_pc;
        end
    end

    assign pc = pc_q;
endmodule

// File: rtl/useq_next_pc_chk.sv
module useq_next_pc_chk #(
    parameter int PC_W    = 23,
    parameter int PAGE_W  = 12,
    parameter int CALL_LO = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            stall,
    input logic [2:0]      cat,
    input logic [1:0]      npc_sel,
    input logic [2:0]      call_op,
    input logic [PC_W-1:0] addr_field,
    input logic [PC_W-1:0] alu_out,
    input logic [PC_W-1:0] pc,
    input logic            illegal,
    input logic            cond_take
);
    localparam logic [PC_W-1:0] ONE = PC_W'(1);

    logic go;
    logic alu_cat;
    logic calling;
    assign go      = !stall && cond_take && !illegal;
    assign alu_cat = (cat == 3'd0) || (cat == 3'd4);
    assign calling = (call_op == 3'd4) || (call_op == 3'd5) || (call_op == 3'd6);

    AST_RESET_PC: assert property (@(posedge clk)
        rst |=> pc == '0);  // R1

    AST_SEL_ALUOUT: assert property (@(posedge clk) disable iff (rst)
        go && npc_sel == 2'd1 |=> pc == $past(alu_out));  // R2

    AST_FULL_ADDR: assert property (@(posedge clk) disable iff (rst)
        go && npc_sel == 2'd0 && cat == 3'd3 |=> pc == $past(addr_field));  // R3

    AST_PAGE_KEEP: assert property (@(posedge clk) disable iff (rst)
        go && npc_sel == 2'd0 && alu_cat && !calling
        |=> pc[PC_W-1:PAGE_W] == $past(pc[PC_W-1:PAGE_W]));  // R4

    AST_CALL_ZERO: assert property (@(posedge clk) disable iff (rst)
        go && npc_sel == 2'd0 && alu_cat && calling
        |=> pc[PC_W-1:PAGE_W] == '0 && pc[CALL_LO-1:0] == '0);  // R5

    AST_RET_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
        npc_sel == 2'd2 && call_op != 3'd7 |-> illegal);  // R6

    AST_NOADDR_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
        npc_sel == 2'd0 && !alu_cat && cat != 3'd3 |-> illegal);  // R7

    AST_ILLEGAL_SEQ: assert property (@(posedge clk) disable iff (rst)
        !stall && illegal |=> pc == $past(pc) + ONE);  // R6

    AST_FALSE_SEQ: assert property (@(posedge clk) disable iff (rst)
        !stall && !cond_take |=> pc == $past(pc) + ONE);  // R10

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        stall |=> pc == $past(pc));  // R11
endmodule

bind useq_next_pc useq_next_pc_chk #(
    .PC_W    (PC_W),
    .PAGE_W  (PAGE_W),
    .CALL_LO (CALL_LO)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .stall      (stall),
    .cat        (cat),
    .npc_sel    (npc_sel),
    .call_op    (call_op),
    .addr_field (addr_field),
    .alu_out    (alu_out),
    .pc         (pc),
    .illegal    (illegal),
    .cond_take  (cond_take)
);

// File: tb/useq_next_pc_tb_top.sv
`timescale 1ns/1ps
module useq_next_pc_tb_top;
    localparam int PC_W = 23;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            stall = 1'b0;
    logic [2:0]      cat = 3'd0;
    logic [1:0]      npc_sel = 2'd3;
    logic [2:0]      jcond = 3'd1;
    logic [2:0]      call_op = 3'd0;
    logic [PC_W-1:0] addr_field = '0;
    logic [PC_W-1:0] alu_out = '0;
    logic [PC_W-1:0] ret_pc = '0;
    logic            flag_c = 1'b0;
    logic            flag_z = 1'b0;
    logic            jindir = 1'b0;
    logic [PC_W-1:0] pc;
    logic            illegal;

    int              n_run = 0;
    int              n_fail = 0;
    bit              done = 1'b0;
    logic [PC_W-1:0] mpc = '0;

    always #10 clk = ~clk;

    useq_next_pc dut_i (
        .clk(clk), .rst(rst), .stall(stall), .cat(cat), .npc_sel(npc_sel),
        .jcond(jcond), .call_op(call_op), .addr_field(addr_field),
        .alu_out(alu_out), .ret_pc(ret_pc), .flag_c(flag_c), .flag_z(flag_z),
        .jindir(jindir), .pc(pc), .illegal(illegal)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive an instruction; inputs must already be set at a falling edge.
    task automatic step(string req, logic [PC_W-1:0] exp_pc, logic exp_ill);
        #2;
        check({req, " illegal"}, 32'(illegal), 32'(exp_ill));
        @(negedge clk);
        check({req, " pc"}, 32'(pc), 32'(exp_pc));
        mpc = exp_pc;
    endtask

    task automatic set_instr(logic [2:0] c, logic [1:0] s, logic [2:0] j, logic [2:0] op,
                             logic [PC_W-1:0] a);
        cat = c; npc_sel = s; jcond = j; call_op = op; addr_field = a;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset pc", 32'(pc), 32'h0);
        rst = 1'b0;
        // held condition must be "always": jump taken with all flags low
        set_instr(3'd3, 2'd0, 3'd1, 3'd0, 23'h012345);
        flag_c = 0; flag_z = 0; jindir = 0;
        step("R1 R3 first jump", 23'h012345, 1'b0);
    endtask

    task automatic t_sources();
        set_instr(3'd0, 2'd1, 3'd1, 3'd0, '0); alu_out = 23'h7ABCD;
        step("R2 alu_out", 23'h07ABCD, 1'b0);
        set_instr(3'd0, 2'd2, 3'd1, 3'd7, '0); ret_pc = 23'h000400;
        step("R2 ret_pc", 23'h000400, 1'b0);
        set_instr(3'd3, 2'd3, 3'd1, 3'd0, 23'h555555);
        step("R2 seq", 23'h000401, 1'b0);
        set_instr(3'd3, 2'd0, 3'd1, 3'd0, 23'h6EDCBA);
        step("R3 full addr", 23'h6EDCBA, 1'b0);
    endtask

    task automatic t_page_call();
        set_instr(3'd3, 2'd0, 3'd1, 3'd0, 23'h5A3123);
        step("R3 setup", 23'h5A3123, 1'b0);
        set_instr(3'd0, 2'd0, 3'd1, 3'd0, 23'h7FFABC);
        step("R4 page alu", 23'h5A3ABC, 1'b0);
        set_instr(3'd4, 2'd0, 3'd1, 3'd7, 23'h000456);
        step("R4 page alux", 23'h5A3456, 1'b0);
        set_instr(3'd0, 2'd0, 3'd1, 3'd4, 23'h7FFAB5);
        step("R5 call", 23'h000AB0, 1'b0);
        set_instr(3'd3, 2'd0, 3'd1, 3'd0, 23'h432100);
        step("R3 setup", 23'h432100, 1'b0);
        set_instr(3'd4, 2'd0, 3'd1, 3'd5, 23'h12345F);
        step("R5 open-call", 23'h000450, 1'b0);
        set_instr(3'd0, 2'd0, 3'd1, 3'd6, 23'h000FFF);
        step("R5 tail call", 23'h000FF0, 1'b0);
    endtask

    task automatic t_illegal();
        set_instr(3'd0, 2'd2, 3'd1, 3'd0, '0); ret_pc = 23'h000100;
        step("R6 return w/o RETURN", mpc + 1'b1, 1'b1);
        set_instr(3'd3, 2'd2, 3'd1, 3'd4, '0);
        step("R6 return on call", mpc + 1'b1, 1'b1);
        for (int k = 1; k < 8; k++) begin
            if (k == 3 || k == 4) continue;
            set_instr(3'(k), 2'd0, 3'd1, 3'd0, 23'h222222);
            step("R7 no address", mpc + 1'b1, 1'b1);
        end
    endtask

    function automatic logic expect_take(int code, logic c, logic z, logic ji);
        case (code)
            0: return ji;
            1: return 1'b1;
            2: return c;
            3: return !c;
            4: return z;
            5: return !z;
            6: return c | z;
            default: return !(c | z);
        endcase
    endfunction

    task automatic t_conditions();
        for (int code = 0; code < 8; code++) begin
            for (int v = 0; v < 8; v++) begin
                logic c, z, ji;
                logic [PC_W-1:0] tgt;
                c = v[0]; z = v[1]; ji = v[2];
                tgt = 23'h100000 + 23'(code * 16 + v);
                // write condition; opposite flags here must not matter
                set_instr(3'd0, 2'd3, 3'(code), 3'd0, '0);
                flag_c = !c; flag_z = !z; jindir = !ji;
                step("R9 cond write", mpc + 1'b1, 1'b0);
                set_instr(3'd3, 2'd0, 3'd1, 3'd0, tgt);
                flag_c = c; flag_z = z; jindir = ji;
                step(expect_take(code, c, z, ji) ? "R8 R9 taken" : "R8 R10 fall through",
                     expect_take(code, c, z, ji) ? tgt : mpc + 1'b1, 1'b0);
            end
        end
        // false condition ignores alu and return sources
        set_instr(3'd0, 2'd3, 3'd2, 3'd0, '0);
        step("R10 write carry", mpc + 1'b1, 1'b0);
        flag_c = 0; set_instr(3'd0, 2'd1, 3'd2, 3'd0, '0); alu_out = 23'h333333;
        step("R10 alu blocked", mpc + 1'b1, 1'b0);
        set_instr(3'd0, 2'd2, 3'd1, 3'd7, '0); ret_pc = 23'h444444;
        step("R10 ret blocked", mpc + 1'b1, 1'b0);
        flag_c = 0; flag_z = 0; jindir = 0;
    endtask

    task automatic t_stall();
        set_instr(3'd3, 2'd0, 3'd1, 3'd0, 23'h0ABCDE);
        step("R11 setup", 23'h0ABCDE, 1'b0);
        stall = 1'b1;
        set_instr(3'd3, 2'd0, 3'd3, 3'd0, 23'h111111);
        flag_c = 1;
        step("R11 stall pc", 23'h0ABCDE, 1'b0);
        step("R11 stall pc again", 23'h0ABCDE, 1'b0);
        stall = 1'b0;
        // held condition must still be "always", so carry=1 does not block
        set_instr(3'd3, 2'd0, 3'd1, 3'd0, 23'h222220);
        step("R11 cond held", 23'h222220, 1'b0);
        flag_c = 0;
    endtask

    task automatic t_wrap();
        set_instr(3'd3, 2'd0, 3'd1, 3'd0, 23'h7FFFFF);
        step("R12 setup", 23'h7FFFFF, 1'b0);
        set_instr(3'd3, 2'd3, 3'd1, 3'd0, '0);
        step("R12 wrap", 23'h000000, 1'b0);
        step("R12 after wrap", 23'h000001, 1'b0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_sources();
        t_page_call();
        t_illegal();
        t_conditions();
        t_stall();
        t_wrap();
        t_reset();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule